// File: doc/BRIEF.md
# APM Command Port SMI Controller

This block sits behind a one-byte power-management command port. Every host write delivers a command byte. Two reserved codes are consumed as ACPI mode switches: one turns the SCI-enable state bit on, the other turns it off, and neither ever reaches the system-management interrupt path. Every other code is a trap request. A trap request raises a level SMI request only when a gate bit in a configuration byte allows it. The request then stays high until software acknowledges it.

The block holds the gate configuration byte and the most recently written command byte. The SMI handler can read that command byte back to learn why it was entered. The reset value of the configuration byte depends on a build parameter that says whether SMM support is present. When SMM support is absent, the byte resets with its gate bit set, which marks SMM as already initialised. When SMM support is present, the byte resets to zero.

Two small state machines carry the behaviour. The mode machine has states ACPI_OFF and ACPI_ON, with transitions "enable" (ACPI_OFF to ACPI_ON on the enable code) and "disable" (ACPI_ON to ACPI_OFF on the disable code). The SMI machine has states SMI_IDLE and SMI_PEND, with transitions "trap" (SMI_IDLE to SMI_PEND on a gated trap request) and "acknowledge" (SMI_PEND to SMI_IDLE on an acknowledge with no trap request in the same cycle). Every other input combination holds the current state.

Top module: `apm_smi_ctrl`

## Requirements
- R1: After reset, `sci_en` is 0, `smi_req` is 0 and `last_cmd` is 0x00. `cfg_q` is 0x02 when SMM_PRESENT is 0 and 0x00 when SMM_PRESENT is 1.
- R2: A write (`cmd_we` high) of byte 0xF1 makes `sci_en` 1 from the next cycle on.
- R3: A write of byte 0xF0 makes `sci_en` 0 from the next cycle on.
- R4: A write of 0xF0 or 0xF1 never causes a rise of `smi_req`, whatever the value of `cfg_q`.
- R5: A write of any byte other than 0xF0 and 0xF1 makes `smi_req` 1 in the next cycle when bit 1 of `cfg_q` is 1. When that bit is 0, such a write leaves `smi_req` unchanged.
- R6: Once `smi_req` is 1, it stays 1 until `smi_ack` is sampled high. It reads 0 in the cycle after that acknowledge, unless R7 applies.
- R7: A gated trap write while `smi_req` is already 1 keeps `smi_req` at 1 with no low cycle. A gated trap write in the same cycle as `smi_ack` also leaves `smi_req` at 1.
- R8: Every command write, including 0xF0 and 0xF1, is presented on `last_cmd` from the next cycle on. Without a write, `last_cmd` holds its value.
- R9: A configuration write (`cfg_we` high) loads `cfg_wdata` into `cfg_q` for the next cycle. A command written in the same cycle is gated by the value `cfg_q` had before that configuration write.
- R10: Writes of any byte other than 0xF0 and 0xF1 leave `sci_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Host write strobe for the command port |
| cmd_wdata | input | 8 | Command byte written by the host |
| cfg_we | input | 1 | Write strobe for the gate configuration byte |
| cfg_wdata | input | 8 | New value for the gate configuration byte |
| smi_ack | input | 1 | Software acknowledge that clears a pending SMI |
| cfg_q | output | 8 | Current gate configuration byte (bit 1 is the SMI gate) |
| sci_en | output | 1 | ACPI SCI-enable state bit |
| smi_req | output | 1 | Level SMI request |
| last_cmd | output | 8 | Most recently written command byte |

## Verification
Both state machines decode straight to output pins, so a wrong state shows at `sci_en` or `smi_req` one cycle after the write or acknowledge that caused it. A wrongly loaded gate byte is visible on `cfg_q` right away. Its effect on the SMI path appears only at the next trap write, which the bench issues often with random gate values. The risky cases are a mode-switch code arriving with the gate open, a trap arriving together with an acknowledge, and a gate change in the same cycle as a trap. The bench drives each of these directly and checks the result on the very next cycle.

// File: rtl/apm_pkg.sv
package apm_pkg;

    // Classification of one host cycle on the command port
    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_ACPI_ON  = 2'd1,
        CMD_ACPI_OFF = 2'd2,
        CMD_TRAP     = 2'd3
    } cmd_kind_e;

    typedef enum logic {
        SMI_IDLE = 1'b0,
        SMI_PEND = 1'b1
    } smi_state_e;

    typedef enum logic {
        ACPI_OFF = 1'b0,
        ACPI_ON  = 1'b1
    } acpi_state_e;

endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
    import apm_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  CODE_ON  = 8'hF1,
    parameter logic [7:0]  CODE_OFF = 8'hF0
) (
    input  logic              we,
    input  logic [DATA_W-1:0] data,
    output cmd_kind_e         kind
);

    localparam logic [DATA_W-1:0] ON_W  = DATA_W'(CODE_ON);
    localparam logic [DATA_W-1:0] OFF_W = DATA_W'(CODE_OFF);

    always_comb begin
        if (!we) begin
            kind = CMD_NONE;
        end else if (data == ON_W) begin
            kind = CMD_ACPI_ON;
        end else if (data == OFF_W) begin
            kind = CMD_ACPI_OFF;
        end else begin
            kind = CMD_TRAP;
        end
    end

    // R4: a mode-switch code is never classified as a trap
    always_comb begin
        if (we && (data == ON_W || data == OFF_W)) begin
            mode_not_trap_chk: assert (kind != CMD_TRAP);
        end
    end

endmodule

// File: rtl/apm_gate_reg.sv
module apm_gate_reg #(
    parameter int DATA_W      = 8,
    parameter int GATE_BIT    = 1,
    parameter bit SMM_PRESENT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic              gate
);

    // Without SMM support the gate bit comes up set ("already initialised")
    localparam logic [DATA_W-1:0] RST_VAL =
        SMM_PRESENT ? '0 : (DATA_W'(1) << GATE_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    assign gate = cfg_q[GATE_BIT];

    // R9
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/apm_sci_fsm.sv
module apm_sci_fsm
    import apm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_e kind,
    output logic      sci_en
);

    acpi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACPI_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACPI_OFF: if (kind == CMD_ACPI_ON)  state_d = ACPI_ON;   // enable
            ACPI_ON:  if (kind == CMD_ACPI_OFF) state_d = ACPI_OFF;  // disable
            default:  state_d = ACPI_OFF;
        endcase
    end

    always_comb begin
        sci_en = (state_q == ACPI_ON);
    end

    // R2
    acpi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_ACPI_ON) |=> sci_en);

    // R3
    acpi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_ACPI_OFF) |=> !sci_en);

    // R10
    acpi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_TRAP || kind == CMD_NONE) |=> $stable(sci_en));

endmodule

// File: rtl/apm_smi_fsm.sv
module apm_smi_fsm
    import apm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_e kind,
    input  logic      gate,
    input  logic      ack,
    output logic      smi_req
);

    smi_state_e state_q, state_d;
    logic       trap_hit;

    always_comb begin
        trap_hit = (kind == CMD_TRAP) && gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // A trap in the same cycle as an acknowledge wins, so no request is lost
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE: if (trap_hit)         state_d = SMI_PEND;  // trap
            SMI_PEND: if (ack && !trap_hit) state_d = SMI_IDLE;  // acknowledge
            default:  state_d = SMI_IDLE;
        endcase
    end

    always_comb begin
        smi_req = (state_q == SMI_PEND);
    end

    // R4
    mode_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == CMD_ACPI_ON || kind == CMD_ACPI_OFF) && (!smi_req || ack)) |=> !smi_req);

    // R5
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == CMD_TRAP) && gate) |=> smi_req);

    // R5
    trap_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == CMD_TRAP) && !gate && !smi_req) |=> !smi_req);

    // R6
    smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !ack) |=> smi_req);

    // R6
    smi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && ack && !((kind == CMD_TRAP) && gate)) |=> !smi_req);

endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl
    import apm_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         GATE_BIT    = 1,
    parameter bit         SMM_PRESENT = 1'b0,
    parameter logic [7:0] CODE_ON     = 8'hF1,
    parameter logic [7:0] CODE_OFF    = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              smi_ack,
    output logic [DATA_W-1:0] cfg_q,
    output logic              sci_en,
    output logic              smi_req,
    output logic [DATA_W-1:0] last_cmd
);

    cmd_kind_e kind;
    logic      gate;

    apm_cmd_decode #(
        .DATA_W  (DATA_W),
        .CODE_ON (CODE_ON),
        .CODE_OFF(CODE_OFF)
    ) u_decode (
        .we  (cmd_we),
        .data(cmd_wdata),
        .kind(kind)
    );

    apm_gate_reg #(
        .DATA_W     (DATA_W),
        .GATE_BIT   (GATE_BIT),
        .SMM_PRESENT(SMM_PRESENT)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_q    (cfg_q),
        .gate     (gate)
    );

    apm_sci_fsm u_sci (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .sci_en(sci_en)
    );

    apm_smi_fsm u_smi (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .gate   (gate),
        .ack    (smi_ack),
        .smi_req(smi_req)
    );

    // Command byte kept for the handler to read back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cmd <= '0;
        end else if (cmd_we) begin
            last_cmd <= cmd_wdata;
        end
    end

    // R8
    last_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (last_cmd == $past(cmd_wdata)));

    // R7
    smi_no_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && cmd_we && gate && cmd_wdata != DATA_W'(CODE_ON)
                && cmd_wdata != DATA_W'(CODE_OFF)) |=> smi_req);

endmodule

// File: tb/sim_apm_smi_ctrl.sv
`timescale 1ns/1ps
module sim_apm_smi_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       smi_ack = 1'b0;
    logic [7:0] cfg_q, last_cmd, cfg_q1, last_cmd1;
    logic       sci_en, smi_req, sci_en1, smi_req1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic       m_sci, m_pend;
    logic [7:0] m_last, m_cfg;

    always #2.5 clk = ~clk;

    apm_smi_ctrl #(.SMM_PRESENT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .smi_ack(smi_ack),
        .cfg_q(cfg_q), .sci_en(sci_en), .smi_req(smi_req), .last_cmd(last_cmd)
    );

    apm_smi_ctrl #(.SMM_PRESENT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_we(1'b0), .cmd_wdata(8'h00),
        .cfg_we(1'b0), .cfg_wdata(8'h00), .smi_ack(1'b0),
        .cfg_q(cfg_q1), .sci_en(sci_en1), .smi_req(smi_req1), .last_cmd(last_cmd1)
    );

    function automatic bit is_mode(input logic [7:0] d);
        return (d == 8'hF1) || (d == 8'hF0);
    endfunction

    function automatic logic f_sci(input logic sci, input logic we, input logic [7:0] d);
        if (we && d == 8'hF1) return 1'b1;
        if (we && d == 8'hF0) return 1'b0;
        return sci;
    endfunction

    function automatic logic f_pend(input logic pend, input logic we, input logic [7:0] d,
                                    input logic [7:0] cfg, input logic ack);
        if (we && !is_mode(d) && cfg[1]) return 1'b1;
        if (ack) return 1'b0;
        return pend;
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge
    task automatic step(input logic we, input logic [7:0] d, input logic ack,
                        input logic cwe, input logic [7:0] cd);
        string tsci, tsmi;
        cmd_we = we; cmd_wdata = d; smi_ack = ack; cfg_we = cwe; cfg_wdata = cd;
        @(posedge clk);
        if (we && d == 8'hF1)      tsci = "R2";
        else if (we && d == 8'hF0) tsci = "R3";
        else                       tsci = "R10";
        if (we && is_mode(d))                      tsmi = "R4";
        else if (we && m_cfg[1] && m_pend)         tsmi = "R7";
        else if (we)                               tsmi = "R5";
        else                                       tsmi = "R6";
        m_sci  = f_sci(m_sci, we, d);
        m_pend = f_pend(m_pend, we, d, m_cfg, ack);
        if (we)  m_last = d;
        if (cwe) m_cfg  = cd;
        #1;
        chk(tsci, "sci_en", {7'd0, sci_en}, {7'd0, m_sci});
        chk(tsmi, "smi_req", {7'd0, smi_req}, {7'd0, m_pend});
        chk("R8", "last_cmd", last_cmd, m_last);
        chk("R9", "cfg_q", cfg_q, m_cfg);
        @(negedge clk);
        cmd_we = 1'b0; smi_ack = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sci = 1'b0; m_pend = 1'b0; m_last = 8'h00; m_cfg = 8'h02;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values on both build variants
        chk("R1", "sci_en", {7'd0, sci_en}, 8'd0);
        chk("R1", "smi_req", {7'd0, smi_req}, 8'd0);
        chk("R1", "last_cmd", last_cmd, 8'h00);
        chk("R1", "cfg_q no-smm", cfg_q, 8'h02);
        chk("R1", "cfg_q smm", cfg_q1, 8'h00);
        chk("R1", "smm sci/smi", {6'd0, sci_en1, smi_req1}, 8'd0);

        // Directed: R2 / R3 with the gate open, no SMI (R4)
        step(1'b1, 8'hF1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 8'hF0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 8'hF1, 1'b0, 1'b0, 8'h00);
        // R5: trap with gate open raises, sci kept (R10)
        step(1'b1, 8'h42, 1'b0, 1'b0, 8'h00);
        // R6: holds without ack
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        // R7: trap while pending
        step(1'b1, 8'h10, 1'b0, 1'b0, 8'h00);
        // R7: trap with ack in the same cycle stays high
        step(1'b1, 8'h11, 1'b1, 1'b0, 8'h00);
        // R4: mode code with ack clears
        step(1'b1, 8'hF0, 1'b1, 1'b0, 8'h00);
        // R9: close gate while trapping: old gate (open) still used
        step(1'b1, 8'h33, 1'b0, 1'b1, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        // R5: gate closed, trap ignored
        step(1'b1, 8'h55, 1'b0, 1'b0, 8'h00);
        // R9: open gate while trapping: old gate (closed) used
        step(1'b1, 8'h56, 1'b0, 1'b1, 8'hFF);
        // R4: mode codes with gate fully open
        step(1'b1, 8'hF1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 8'hF0, 1'b0, 1'b0, 8'h00);
        // boundary neighbours of the mode codes trap
        step(1'b1, 8'hF2, 1'b0, 1'b0, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        step(1'b1, 8'hEF, 1'b0, 1'b0, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            case (sel)
                3'd0:    d = 8'hF1;
                3'd1:    d = 8'hF0;
                default: d = 8'($urandom);
            endcase
            step(1'($urandom_range(0, 2) != 0), d,
                 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 7) == 0),
                 8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule